// File: doc/BRIEF.md
# Post-Detection Write Replayer

This block holds a short program of byte-wide register writes and plays it out to a peripheral when a detection event arrives. A typical use is to power up a codec's converter path the moment voice activity is seen, without waking a processor to do it. The program sits in local registers. Offsets are packed four to a word in a bank of offset words, and the byte values are packed the same way in a matching bank of data words. Every target address is formed by adding the 8-bit offset to a programmable base address.

A run starts when a detection pulse arrives, the trigger enable is set and no run is already in progress. The block then issues single writes, one at a time, on a request/acknowledge port. It moves to the next entry only after the current one has been acknowledged. When the last entry has been acknowledged it drops its busy flag and raises a one-cycle completion pulse. The number of entries comes from a count field written as count minus one, so one to 32 writes are possible.

Top module: `detwr_replay`

## Requirements
- R1: After reset, busy, done and wr_req are low, and all offset words, data words, the base address, the count field and the trigger enable are zero.
- R2: A configuration write at cfg_addr 0..7 loads offset word 0..7, 8..15 loads data word 0..7, 16 loads the base address, and 17 loads the control word, with the trigger enable in bit 22 and the count field (count minus one) in bits 4:0. A write to any other address changes nothing.
- R3: A run starts (busy high in the next cycle) only when det_evt is high, the trigger enable is set and the block is idle. A det_evt with the enable clear has no effect.
- R4: Entry k is byte k mod 4 of word k/4, with byte 0 in bits 7:0. Entries are issued from entry 0 upward, and wr_data carries the data byte of the current entry.
- R5: wr_addr equals the base address plus the zero-extended offset byte of the current entry, with carries into the upper bits.
- R6: A run issues exactly count-field-plus-one writes. A field of 27 gives 28 writes and a field of 31 gives all 32.
- R7: wr_req stays high with wr_addr and wr_data unchanged until wr_ack. The next entry is presented in the cycle after the acknowledge, even when wr_ack is held high continuously.
- R8: In the cycle after the last acknowledge, busy is low and done is high for exactly one cycle. Busy never ends without an acknowledge.
- R9: A det_evt that arrives while busy is ignored. The run neither restarts nor extends.
- R10: Configuration writes that arrive while busy are ignored. The next run sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration register select |
| cfg_wdata | input | WORD_W (32) | Configuration write value |
| det_evt | input | 1 | Detection event pulse |
| wr_req | output | 1 | Write request to the peripheral |
| wr_addr | output | ADDR_W (32) | Target address of the current write |
| wr_data | output | ENTRY_W (8) | Byte value of the current write |
| wr_ack | input | 1 | Peripheral accepts the current write |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |

## Verification
The checker assumes that the peripheral asserts wr_ack only while wr_req is high. It also assumes that det_evt and configuration writes are synchronous single-cycle strobes. The bench drives wr_ack from the sampled wr_req, either every cycle or after random gaps, and never lets it stand alone. It changes det_evt and the configuration strobes only on falling edges. Detection pulses that must be ignored are placed well inside a run, away from the completion cycle, so no ignored pulse can land on a cycle where a new start would be legal.

// File: rtl/detwr_pkg.sv
package detwr_pkg;

   typedef enum logic [2:0] {
      CFG_OFS,
      CFG_DAT,
      CFG_BASE,
      CFG_CTRL,
      CFG_NONE
   } cfg_kind_e;

   typedef enum logic {
      ST_IDLE,
      ST_RUN
   } seq_state_e;

   // map a configuration address onto its register class
   function automatic cfg_kind_e cfg_decode(input int unsigned a, input int unsigned nw);
      if (a < nw)               return CFG_OFS;
      else if (a < 2 * nw)      return CFG_DAT;
      else if (a == 2 * nw)     return CFG_BASE;
      else if (a == 2 * nw + 1) return CFG_CTRL;
      else                      return CFG_NONE;
   endfunction

endpackage

// File: rtl/detwr_cfg_regs.sv
module detwr_cfg_regs
   import detwr_pkg::*;
#(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned CNT_LSB   = 0,
   parameter int unsigned EN_BIT    = 22,
   parameter int unsigned CFG_AW    = 5,
   localparam int unsigned BANK_W   = NUM_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              lock,
   output logic [BANK_W-1:0] ofs_flat,
   output logic [BANK_W-1:0] dat_flat,
   output logic [ADDR_W-1:0] base_q,
   output logic [CNT_W-1:0]  cnt_m1_q,
   output logic              trig_en_q
);

   logic      accept;
   cfg_kind_e kind;

   // R10: the list is frozen while a run is in progress
   assign accept = cfg_we && !lock;
   assign kind   = cfg_decode(32'(cfg_addr), NUM_WORDS);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] ofs_r;
      logic [WORD_W-1:0] dat_r;
      logic              hit_ofs;
      logic              hit_dat;

      assign hit_ofs = accept && (kind == CFG_OFS) && (cfg_addr == CFG_AW'(w));
      assign hit_dat = accept && (kind == CFG_DAT) && (cfg_addr == CFG_AW'(w + NUM_WORDS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ofs_r <= '0;
            dat_r <= '0;
         end else begin
            if (hit_ofs) ofs_r <= cfg_wdata;
            if (hit_dat) dat_r <= cfg_wdata;
         end
      end

      assign ofs_flat[w*WORD_W +: WORD_W] = ofs_r;
      assign dat_flat[w*WORD_W +: WORD_W] = dat_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q    <= '0;
         cnt_m1_q  <= '0;
         trig_en_q <= 1'b0;
      end else if (accept) begin
         if (kind == CFG_BASE) begin
            base_q <= cfg_wdata[ADDR_W-1:0];
         end
         if (kind == CFG_CTRL) begin
            cnt_m1_q  <= cfg_wdata[CNT_LSB +: CNT_W];
            trig_en_q <= cfg_wdata[EN_BIT];
         end
      end
   end

endmodule

// File: rtl/detwr_entry_sel.sv
module detwr_entry_sel #(
   parameter int unsigned NUM_ENT = 32,
   parameter int unsigned ENTRY_W = 8,
   parameter int unsigned IDX_W   = 5
) (
   input  logic [NUM_ENT*ENTRY_W-1:0] bank,
   input  logic [IDX_W-1:0]           idx,
   output logic [ENTRY_W-1:0]         entry
);

   logic [ENTRY_W-1:0] ent [NUM_ENT];

   // entry k lives in byte (k mod per-word) of word (k / per-word)
   for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
      assign ent[k] = bank[k*ENTRY_W +: ENTRY_W];
   end

   assign entry = ent[idx];

endmodule

// File: rtl/detwr_seq.sv
module detwr_seq
   import detwr_pkg::*;
#(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             det_evt,
   input  logic             trig_en,
   input  logic [CNT_W-1:0] cnt_m1,
   input  logic             wr_ack,
   output logic             busy,
   output logic [CNT_W-1:0] idx,
   output logic             done
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   seq_state_e       state_q;
   logic [CNT_W-1:0] idx_q;
   logic             done_q;
   logic             last;

   assign last = (idx_q == cnt_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (det_evt && trig_en) begin
                  state_q <= ST_RUN;
                  idx_q   <= '0;
               end
            end
            ST_RUN: begin
               // R9: detection pulses are not looked at here
               if (wr_ack) begin
                  if (last) begin
                     state_q <= ST_IDLE;
                     idx_q   <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + ONE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q == ST_RUN);
   assign idx  = idx_q;
   assign done = done_q;

endmodule

// File: rtl/detwr_replay.sv
module detwr_replay #(
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned ENTRY_W   = 8,
   parameter int unsigned PER_WORD  = 4,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned EN_BIT    = 22,
   parameter int unsigned CNT_LSB   = 0,
   localparam int unsigned WORD_W   = ENTRY_W * PER_WORD,
   localparam int unsigned NUM_ENT  = NUM_WORDS * PER_WORD,
   localparam int unsigned CNT_W    = $clog2(NUM_ENT),
   localparam int unsigned CFG_AW   = $clog2(2 * NUM_WORDS + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              det_evt,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ENTRY_W-1:0] wr_data,
   input  logic              wr_ack,
   output logic              busy,
   output logic              done
);

   localparam int unsigned BANK_W = NUM_WORDS * WORD_W;

   // elaboration-time parameter checks
   if (NUM_ENT < 2 || (NUM_ENT & (NUM_ENT - 1)) != 0) begin : g_bad_ent
      $error("entry count must be a power of two of at least 2");
   end
   if (ADDR_W <= ENTRY_W || ADDR_W > WORD_W) begin : g_bad_addr
      $error("address width must exceed an entry and fit a word");
   end
   if (EN_BIT >= WORD_W || CNT_LSB + CNT_W > WORD_W) begin : g_bad_fit
      $error("control fields must fit in a word");
   end
   if (EN_BIT >= CNT_LSB && EN_BIT < CNT_LSB + CNT_W) begin : g_bad_overlap
      $error("enable bit overlaps the count field");
   end

   logic [BANK_W-1:0]  ofs_flat;
   logic [BANK_W-1:0]  dat_flat;
   logic [ADDR_W-1:0]  base_q;
   logic [CNT_W-1:0]   cnt_m1_q;
   logic               trig_en_q;
   logic [CNT_W-1:0]   idx;
   logic [ENTRY_W-1:0] ofs_ent;
   logic [ENTRY_W-1:0] dat_ent;
   logic               busy_i;

   detwr_cfg_regs #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .CNT_LSB   (CNT_LSB),
      .EN_BIT    (EN_BIT),
      .CFG_AW    (CFG_AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .lock      (busy_i),
      .ofs_flat  (ofs_flat),
      .dat_flat  (dat_flat),
      .base_q    (base_q),
      .cnt_m1_q  (cnt_m1_q),
      .trig_en_q (trig_en_q)
   );

   detwr_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .det_evt (det_evt),
      .trig_en (trig_en_q),
      .cnt_m1  (cnt_m1_q),
      .wr_ack  (wr_ack),
      .busy    (busy_i),
      .idx     (idx),
      .done    (done)
   );

   detwr_entry_sel #(
      .NUM_ENT (NUM_ENT),
      .ENTRY_W (ENTRY_W),
      .IDX_W   (CNT_W)
   ) u_sel_ofs (
      .bank  (ofs_flat),
      .idx   (idx),
      .entry (ofs_ent)
   );

   detwr_entry_sel #(
      .NUM_ENT (NUM_ENT),
      .ENTRY_W (ENTRY_W),
      .IDX_W   (CNT_W)
   ) u_sel_dat (
      .bank  (dat_flat),
      .idx   (idx),
      .entry (dat_ent)
   );

   assign wr_req  = busy_i;
   assign wr_addr = base_q + {{(ADDR_W-ENTRY_W){1'b0}}, ofs_ent};
   assign wr_data = dat_ent;
   assign busy    = busy_i;

endmodule

// File: rtl/detwr_chk.sv
module detwr_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ENTRY_W = 8,
   parameter int unsigned CNT_W   = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               det_evt,
   input logic               trig_en,
   input logic [CNT_W-1:0]   cnt_m1,
   input logic               wr_req,
   input logic               wr_ack,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [ENTRY_W-1:0] wr_data,
   input logic               busy,
   input logic               done
);

   logic [CNT_W:0] run_acks;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_acks <= '0;
      else if (wr_req && wr_ack) run_acks <= run_acks + 1'b1;
      else if (done)             run_acks <= '0;
   end

   // R3
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(det_evt && trig_en));

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

   // R8
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy && wr_ack)));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R6
   write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_acks == ({1'b0, cnt_m1} + 1'b1)));

endmodule

bind detwr_replay detwr_chk #(
   .ADDR_W  (ADDR_W),
   .ENTRY_W (ENTRY_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .det_evt (det_evt),
   .trig_en (trig_en_q),
   .cnt_m1  (cnt_m1_q),
   .wr_req  (wr_req),
   .wr_ack  (wr_ack),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .busy    (busy),
   .done    (done)
);

// File: tb/detwr_replay_tb.sv
module detwr_replay_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        det_evt = 1'b0;
   logic        wr_req;
   logic [31:0] wr_addr;
   logic [7:0]  wr_data;
   logic        wr_ack = 1'b0;
   logic        busy;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int ack_mode = 0;
   int run_acks = 0;

   // reference model state
   logic [31:0] m_ofs [8];
   logic [31:0] m_dat [8];
   logic [31:0] m_base;
   int          m_cnt;
   bit          m_en;
   bit          m_busy;
   bit          m_done;
   int          m_idx;

   always #4 clk = ~clk;

   detwr_replay u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .det_evt   (det_evt),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .wr_ack    (wr_ack),
      .busy      (busy),
      .done      (done)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   function automatic logic [7:0] byte_of(input logic [31:0] w, input int b);
      return w[b*8 +: 8];
   endfunction

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      bit en_old;
      cyc++;
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin
            m_ofs[i] = '0;
            m_dat[i] = '0;
         end
         m_base = '0; m_cnt = 0; m_en = 0;
         m_busy = 0; m_done = 0; m_idx = 0;
      end else begin
         if (wr_req && wr_ack) run_acks++;
         en_old = m_en;
         m_done = 0;
         if (m_busy) begin
            if (wr_ack) begin
               if (m_idx == m_cnt) begin
                  m_busy = 0;
                  m_done = 1;
                  m_idx  = 0;
               end else begin
                  m_idx++;
               end
            end
         end else begin
            if (cfg_we) begin
               if (cfg_addr < 8)       m_ofs[cfg_addr] = cfg_wdata;
               else if (cfg_addr < 16) m_dat[cfg_addr - 8] = cfg_wdata;
               else if (cfg_addr == 16) m_base = cfg_wdata;
               else if (cfg_addr == 17) begin
                  m_en  = cfg_wdata[22];
                  m_cnt = int'(cfg_wdata[4:0]);
               end
            end
            if (det_evt && en_old) begin
               m_busy = 1;
               m_idx  = 0;
            end
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 busy", {31'b0, busy}, {31'b0, m_busy});
         chk("R8 done", {31'b0, done}, {31'b0, m_done});
         chk("R7 req", {31'b0, wr_req}, {31'b0, m_busy});
         if (m_busy) begin
            chk("R5 addr", wr_addr, m_base + {24'b0, byte_of(m_ofs[m_idx/4], m_idx%4)});
            chk("R4 data", {24'b0, wr_data}, {24'b0, byte_of(m_dat[m_idx/4], m_idx%4)});
         end
      end
   end

   // peripheral acknowledge, only while a request is up
   always @(negedge clk) begin
      if (ack_mode == 0) wr_ack = wr_req;
      else               wr_ack = wr_req && (($urandom % 3) != 0);
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc == 100000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic cfg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_det;
      @(negedge clk);
      det_evt = 1'b1;
      @(negedge clk);
      det_evt = 1'b0;
   endtask

   task automatic wait_done;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (done) break;
      end
   endtask

   task automatic load_pattern;
      for (int w = 0; w < 8; w++) begin
         logic [31:0] ov, dv;
         for (int b = 0; b < 4; b++) begin
            ov[b*8 +: 8] = 8'((w*4 + b) * 7 + 3);
            dv[b*8 +: 8] = 8'hA0 ^ 8'(w*4 + b);
         end
         cfg_wr(w, ov);
         cfg_wr(8 + w, dv);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 busy", {31'b0, busy}, 32'd0);
      chk("R1 req", {31'b0, wr_req}, 32'd0);
      chk("R1 done", {31'b0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: enable clear, detection ignored
      pulse_det();
      chk("R3 no start when disabled", {31'b0, busy}, 32'd0);

      // R1: reset contents drive a single write to address 0 with data 0
      cfg_wr(17, 32'h0040_0000);
      run_acks = 0;
      pulse_det();
      chk("R1 first addr zero", wr_addr, 32'd0);
      wait_done();
      chk("R6 single write", run_acks, 1);

      // R6: 28 writes from seven word pairs, base with carry (R5)
      load_pattern();
      cfg_wr(16, 32'h0000_FFF0);
      cfg_wr(17, 32'h0040_001B);
      ack_mode = 1;
      run_acks = 0;
      pulse_det();
      chk("R5 carry addr", wr_addr, 32'h0000_FFF3);
      chk("R4 first data", {24'b0, wr_data}, 32'h0000_00A0);
      // R9: detection pulses during the run are ignored
      repeat (3) @(negedge clk);
      pulse_det();
      pulse_det();
      // R10: configuration writes during the run are ignored
      cfg_wr(0, 32'h5555_5555);
      cfg_wr(16, 32'h1234_0000);
      wait_done();
      chk("R6 28 writes", run_acks, 28);
      repeat (2) @(negedge clk);
      chk("R9 no restart", {31'b0, busy}, 32'd0);

      // R10: next run still sees old offsets and base; R6: full 32 entries
      cfg_wr(17, 32'h0040_001F);
      ack_mode = 0;
      run_acks = 0;
      pulse_det();
      chk("R10 old contents kept", wr_addr, 32'h0000_FFF3);
      wait_done();
      chk("R6 32 writes", run_acks, 32);

      // R2: unused addresses change nothing; base reload takes effect
      cfg_wr(20, 32'hFFFF_FFFF);
      cfg_wr(31, 32'hFFFF_FFFF);
      cfg_wr(16, 32'h2000_0000);
      cfg_wr(17, 32'h0040_0003);
      ack_mode = 1;
      run_acks = 0;
      pulse_det();
      chk("R2 decode base", wr_addr, 32'h2000_0003);
      wait_done();
      chk("R6 four writes", run_acks, 4);

      // R3: enable cleared again, no start
      cfg_wr(17, 32'h0000_0003);
      pulse_det();
      chk("R3 disabled again", {31'b0, busy}, 32'd0);

      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule